// File: doc/BRIEF.md
# Quad DAC command decoder

This block holds the register state of a four-channel digital-to-analog converter. Every channel has an output range (span, 4 bits) and a sample value (code, 16 bits). Each of the two is stored twice: once in an input stage that the host loads, and once in an active stage that drives the converter. A byte-wide host port exposes a low data byte, a high data byte, a command byte and a status byte. The host places data in the two data bytes and then writes the command byte. That command loads the input stage, copies the input stage to the active stage, or does both.

The update commands can act on one channel or on all four. This lets software change several channels and then switch them over at the same time. Readback commands copy a chosen input or active value into the two data bytes, where the host can read it. A ready flag in the status byte goes low on every command write. It returns high a fixed number of cycles later.

Window offsets: 0 is the low data byte, 1 is the high data byte, 2 is the command byte and 3 is the status byte. Status bit 7 is the ready flag. The other status bits read as zero.

Top module: `quad_dac_regs`

## Requirements
- R1: After reset, all input and active spans and codes are zero, both data bytes are zero and ready is 1.
- R2: A write to offset 0 or 1 stores the byte, and a read of the same offset returns it. A read of offset 2 returns the last command byte. A read of offset 3 returns {ready, 7'b0}.
- R3: Opcode 0x2 (command bits 7:4) copies data-low bits 3:0 into the input span of the selected channels. The active stage does not change.
- R4: Opcode 0x3 copies {data-high, data-low} into the input code of the selected channels. The active stage does not change.
- R5: Opcode 0x4 copies both input span and input code into the active stage of the selected channels only.
- R6: Opcode 0x5 copies input to active for all four channels, whatever the channel field holds.
- R7: Opcodes 0x6 and 0x7 do the span write (0x6) or the code write (0x7) and then update the selected channels. Opcodes 0x8 and 0x9 do the same write to the selected channels and then update all four channels. A value written in the same command reaches the active stage directly.
- R8: Command bits 2:1 select the channel. A low nibble of 0xF selects all four channels for writes and updates. A readback with low nibble 0xF reads channel 3.
- R9: Opcodes 0xA and 0xB read back the input span and input code, and 0xC and 0xD read back the active span and active code. The value goes into the data bytes, with the span zero-extended to 16 bits.
- R10: Opcodes 0x0, 0x1, 0xE and 0xF change no span, code or data byte.
- R11: Every command write drops ready at the next clock edge. Ready rises again exactly BUSY_CYCLES edges after the write. A new command restarts this count.
- R12: The active outputs change only at the clock edge that follows a command write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the byte port |
| wr_addr_i | input | 2 | Write offset |
| wr_data_i | input | 8 | Write byte |
| rd_addr_i | input | 2 | Read offset |
| rd_data_o | output | 8 | Read byte (combinational) |
| ready_o | output | 1 | Command-finished flag |
| code_o | output | 64 | Active codes; channel c is at [16c+15:16c] |
| span_o | output | 16 | Active spans; channel c is at [4c+3:4c] |

## Verification
The assertions check the ready timing against an independent cycle counter on every cycle. They also check that the active outputs hold steady whenever no command arrives, and that no-op and write-only commands leave the active outputs alone. Other behaviour can only be shown by the bench's scenarios, which compare against a reference model. This covers the routing of a command's data to the right channel, the difference between selected and broadcast updates, the data that reaches the data bytes on a readback, and the channel that the all-channels code reads back.

// File: rtl/quad_dac_pkg.sv
package quad_dac_pkg;
  localparam int NCH    = 4;
  localparam int CODE_W = 16;
  localparam int SPAN_W = 4;
  localparam int CH_W   = $clog2(NCH);

  typedef enum logic [3:0] {
    OP_WR_SPAN       = 4'h2,
    OP_WR_CODE       = 4'h3,
    OP_UPD           = 4'h4,
    OP_UPD_ALL       = 4'h5,
    OP_WR_SPAN_UPD   = 4'h6,
    OP_WR_CODE_UPD   = 4'h7,
    OP_WR_SPAN_UPDA  = 4'h8,
    OP_WR_CODE_UPDA  = 4'h9,
    OP_RB_IN_SPAN    = 4'hA,
    OP_RB_IN_CODE    = 4'hB,
    OP_RB_ACT_SPAN   = 4'hC,
    OP_RB_ACT_CODE   = 4'hD
  } dac_op_e;

  typedef enum logic [1:0] {
    OFS_LO  = 2'd0,
    OFS_HI  = 2'd1,
    OFS_CMD = 2'd2,
    OFS_ST  = 2'd3
  } dac_ofs_e;
endpackage

// File: rtl/dac_cmd_decode.sv
module dac_cmd_decode
  import quad_dac_pkg::*;
(
  input  logic            cmd_we_i,
  input  logic [7:0]      cmd_i,
  output logic [NCH-1:0]  wr_span_o,
  output logic [NCH-1:0]  wr_code_o,
  output logic [NCH-1:0]  upd_o,
  output logic            rb_en_o,
  output logic            rb_act_o,
  output logic            rb_code_o,
  output logic [CH_W-1:0] rb_ch_o
);
  logic [3:0]     op;
  logic [NCH-1:0] sel;

  assign op = cmd_i[7:4];
  // channel field sits in bits 2:1; low nibble of all ones means broadcast
  assign sel = (cmd_i[3:0] == 4'hF) ? {NCH{1'b1}} : NCH'(1) << cmd_i[2:1];
  assign rb_ch_o = cmd_i[2:1];

  always_comb begin
    wr_span_o = '0;
    wr_code_o = '0;
    upd_o     = '0;
    rb_en_o   = 1'b0;
    rb_act_o  = 1'b0;
    rb_code_o = 1'b0;
    if (cmd_we_i) begin
      case (op)
        OP_WR_SPAN:      wr_span_o = sel;
        OP_WR_CODE:      wr_code_o = sel;
        OP_UPD:          upd_o = sel;
        OP_UPD_ALL:      upd_o = '1;
        OP_WR_SPAN_UPD:  begin wr_span_o = sel; upd_o = sel; end
        OP_WR_CODE_UPD:  begin wr_code_o = sel; upd_o = sel; end
        OP_WR_SPAN_UPDA: begin wr_span_o = sel; upd_o = '1; end
        OP_WR_CODE_UPDA: begin wr_code_o = sel; upd_o = '1; end
        OP_RB_IN_SPAN:   rb_en_o = 1'b1;
        OP_RB_IN_CODE:   begin rb_en_o = 1'b1; rb_code_o = 1'b1; end
        OP_RB_ACT_SPAN:  begin rb_en_o = 1'b1; rb_act_o = 1'b1; end
        OP_RB_ACT_CODE:  begin rb_en_o = 1'b1; rb_act_o = 1'b1; rb_code_o = 1'b1; end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dac_chan_regs.sv
module dac_chan_regs
  import quad_dac_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_span_i,
  input  logic              wr_code_i,
  input  logic              upd_i,
  input  logic [SPAN_W-1:0] span_d_i,
  input  logic [CODE_W-1:0] code_d_i,
  output logic [SPAN_W-1:0] in_span_o,
  output logic [CODE_W-1:0] in_code_o,
  output logic [SPAN_W-1:0] act_span_o,
  output logic [CODE_W-1:0] act_code_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_span_o  <= '0;
      in_code_o  <= '0;
      act_span_o <= '0;
      act_code_o <= '0;
    end else begin
      if (wr_span_i) in_span_o <= span_d_i;
      if (wr_code_i) in_code_o <= code_d_i;
      if (upd_i) begin
        act_span_o <= wr_span_i ? span_d_i : in_span_o;
        act_code_o <= wr_code_i ? code_d_i : in_code_o;
      end
    end
  end
endmodule

// File: rtl/quad_dac_regs.sv
module quad_dac_regs
  import quad_dac_pkg::*;
#(
  parameter int BUSY_CYCLES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [1:0]        rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic              ready_o,
  output logic [NCH*CODE_W-1:0] code_o,
  output logic [NCH*SPAN_W-1:0] span_o
);
  localparam int BW = $clog2(BUSY_CYCLES + 1);

  logic [7:0]     lo_q, hi_q, cmd_q;
  logic [BW-1:0]  busy_q;
  logic           cmd_we;
  logic [NCH-1:0] wr_span, wr_code, upd;
  logic           rb_en, rb_act, rb_code;
  logic [CH_W-1:0] rb_ch;
  logic [SPAN_W-1:0] in_span  [NCH];
  logic [CODE_W-1:0] in_code  [NCH];
  logic [SPAN_W-1:0] act_span [NCH];
  logic [CODE_W-1:0] act_code [NCH];
  logic [CODE_W-1:0] rb_val;

  assign cmd_we = wr_en_i && (wr_addr_i == OFS_CMD);

  dac_cmd_decode u_dec (
    .cmd_we_i  (cmd_we),
    .cmd_i     (wr_data_i),
    .wr_span_o (wr_span),
    .wr_code_o (wr_code),
    .upd_o     (upd),
    .rb_en_o   (rb_en),
    .rb_act_o  (rb_act),
    .rb_code_o (rb_code),
    .rb_ch_o   (rb_ch)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dac_chan_regs u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_span_i  (wr_span[c]),
      .wr_code_i  (wr_code[c]),
      .upd_i      (upd[c]),
      .span_d_i   (lo_q[SPAN_W-1:0]),
      .code_d_i   ({hi_q, lo_q}),
      .in_span_o  (in_span[c]),
      .in_code_o  (in_code[c]),
      .act_span_o (act_span[c]),
      .act_code_o (act_code[c])
    );
    assign code_o[c*CODE_W +: CODE_W] = act_code[c];
    assign span_o[c*SPAN_W +: SPAN_W] = act_span[c];
  end

  always_comb begin
    case ({rb_act, rb_code})
      2'b00:   rb_val = CODE_W'(in_span[rb_ch]);
      2'b01:   rb_val = in_code[rb_ch];
      2'b10:   rb_val = CODE_W'(act_span[rb_ch]);
      default: rb_val = act_code[rb_ch];
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q   <= '0;
      hi_q   <= '0;
      cmd_q  <= '0;
      busy_q <= '0;
    end else begin
      if (wr_en_i && wr_addr_i == OFS_LO) lo_q <= wr_data_i;
      if (wr_en_i && wr_addr_i == OFS_HI) hi_q <= wr_data_i;
      if (rb_en) begin
        lo_q <= rb_val[7:0];
        hi_q <= rb_val[15:8];
      end
      if (cmd_we) begin
        cmd_q  <= wr_data_i;
        busy_q <= BW'(BUSY_CYCLES);
      end else if (busy_q != '0) begin
        busy_q <= busy_q - 1'b1;
      end
    end
  end

  assign ready_o = (busy_q == '0);

  always_comb begin
    case (rd_addr_i)
      OFS_LO:  rd_data_o = lo_q;
      OFS_HI:  rd_data_o = hi_q;
      OFS_CMD: rd_data_o = cmd_q;
      default: rd_data_o = {ready_o, 7'b0};
    endcase
  end
endmodule

// File: rtl/quad_dac_regs_chk.sv
module quad_dac_regs_chk #(
  parameter int BUSY_CYCLES = 4
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [1:0]  wr_addr_i,
  input logic [7:0]  wr_data_i,
  input logic        ready_o,
  input logic [63:0] code_o,
  input logic [15:0] span_o
);
  logic       cmd;
  logic [7:0] since_q;
  logic       touches_act;

  assign cmd = wr_en_i && (wr_addr_i == 2'd2);
  assign touches_act = (wr_data_i[7:4] >= 4'h4) && (wr_data_i[7:4] <= 4'h9);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) since_q <= 8'(BUSY_CYCLES);
    else if (cmd) since_q <= '0;
    else if (since_q < 8'(BUSY_CYCLES)) since_q <= since_q + 1'b1;
  end

  AST_READY_TIMING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o == (since_q >= 8'(BUSY_CYCLES))); // R11

  AST_READY_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd |=> !ready_o); // R11

  AST_ACT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd |=> ($stable(code_o) && $stable(span_o))); // R12

  AST_NO_UPDATE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd && !touches_act) |=> ($stable(code_o) && $stable(span_o))); // R10
endmodule

bind quad_dac_regs quad_dac_regs_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .wr_data_i (wr_data_i),
  .ready_o   (ready_o),
  .code_o    (code_o),
  .span_o    (span_o)
);

// File: tb/tb_quad_dac_regs.sv
module tb_quad_dac_regs;
  localparam int BUSY = 4;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [1:0]  wr_addr = 0;
  logic [7:0]  wr_data = 0;
  logic [1:0]  rd_addr = 0;
  logic [7:0]  rd_data;
  logic        ready;
  logic [63:0] code;
  logic [15:0] span;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [3:0]  m_ispan [4];
  logic [15:0] m_icode [4];
  logic [3:0]  m_aspan [4];
  logic [15:0] m_acode [4];
  logic [7:0]  m_lo, m_hi, m_cmd;

  always #10 clk = ~clk;

  quad_dac_regs #(.BUSY_CYCLES(BUSY)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .ready_o(ready), .code_o(code), .span_o(span)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  // reference model of one command
  task automatic model_cmd(input logic [7:0] c);
    logic [3:0] op;
    logic [3:0] sel;
    logic [1:0] ch;
    bit ws, wc;
    logic [3:0] up;
    logic [15:0] v;
    op = c[7:4];
    ch = c[2:1];
    sel = (c[3:0] == 4'hF) ? 4'hF : 4'(1) << ch;
    ws = (op == 2 || op == 6 || op == 8);
    wc = (op == 3 || op == 7 || op == 9);
    up = (op == 4 || op == 6 || op == 7) ? sel : (op == 5 || op == 8 || op == 9) ? 4'hF : 4'h0;
    m_cmd = c;
    for (int i = 0; i < 4; i++) begin
      if (ws && sel[i]) m_ispan[i] = m_lo[3:0];
      if (wc && sel[i]) m_icode[i] = {m_hi, m_lo};
      if (up[i]) begin m_aspan[i] = m_ispan[i]; m_acode[i] = m_icode[i]; end
    end
    if (op >= 4'hA && op <= 4'hD) begin
      case (op)
        4'hA: v = 16'(m_ispan[ch]);
        4'hB: v = m_icode[ch];
        4'hC: v = 16'(m_aspan[ch]);
        default: v = m_acode[ch];
      endcase
      m_lo = v[7:0]; m_hi = v[15:8];
    end
  endtask

  task automatic check_state(input string req);
    logic [63:0] ec;
    logic [15:0] es;
    logic [7:0] b;
    for (int i = 0; i < 4; i++) begin
      ec[i*16 +: 16] = m_acode[i];
      es[i*4 +: 4] = m_aspan[i];
    end
    chk({req, " code"}, code, ec);
    chk({req, " span"}, span, 64'(es));
    rd(2'd0, b); chk({req, " lo"}, b, m_lo);
    rd(2'd1, b); chk({req, " hi"}, b, m_hi);
  endtask

  // issue command, check R11 ready timing, then state
  task automatic cmd(input logic [7:0] c, input string req);
    logic [7:0] b;
    wr(2'd2, c);
    model_cmd(c);
    chk("R11 drop", ready, 0);
    for (int k = 0; k < BUSY - 1; k++) begin
      @(negedge clk);
      chk("R11 low", ready, 0);
    end
    @(negedge clk);
    chk("R11 rise", ready, 1);
    rd(2'd3, b); chk("R2 status", b, 8'h80);
    rd(2'd2, b); chk("R2 cmdreg", b, m_cmd);
    check_state(req);
  endtask

  task automatic data(input logic [15:0] v);
    wr(2'd0, v[7:0]); wr(2'd1, v[15:8]);
    m_lo = v[7:0]; m_hi = v[15:8];
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    void'($urandom(32'h5eed1234));
    for (int i = 0; i < 4; i++) begin
      m_ispan[i] = 0; m_icode[i] = 0; m_aspan[i] = 0; m_acode[i] = 0;
    end
    m_lo = 0; m_hi = 0; m_cmd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready", ready, 1);
    check_state("R1");
    // R2 data bytes
    data(16'hA55A);
    rd(2'd0, b); chk("R2 lo", b, 8'h5A);
    rd(2'd1, b); chk("R2 hi", b, 8'hA5);
    // R3 span write ch1, active untouched
    data(16'h00F7);
    cmd(8'h22, "R3");
    cmd(8'hA2, "R9 R3 rb in span");
    // R4 code write ch2
    data(16'hBEEF);
    cmd(8'h34, "R4");
    cmd(8'hB4, "R9 R4 rb in code");
    // R5 update ch2 only
    cmd(8'h44, "R5");
    cmd(8'hD4, "R9 rb act code");
    // R6 update all with channel field 0
    cmd(8'h50, "R6");
    cmd(8'hC2, "R9 rb act span");
    // R7 combined variants
    data(16'h1234);
    cmd(8'h76, "R7 code+upd ch3");
    data(16'h0009);
    cmd(8'h60, "R7 span+upd ch0");
    data(16'h0003);
    cmd(8'h22, "R3 stage ch1");
    data(16'hCAFE);
    cmd(8'h90, "R7 code+upd all");
    data(16'h000C);
    cmd(8'h84, "R7 span+upd all");
    // R8 broadcast and readback of 0xF
    data(16'h7777);
    cmd(8'h3F, "R8 code all");
    cmd(8'h4F, "R8 upd all");
    cmd(8'hDF, "R8 rb ch3");
    // R10 no-ops
    data(16'h4242);
    cmd(8'h05, "R10 op0");
    cmd(8'h1F, "R10 op1");
    cmd(8'hE2, "R10 opE");
    cmd(8'hFF, "R10 opF");
    // R11 restart while busy
    wr(2'd2, 8'h00); model_cmd(8'h00);
    wr(2'd2, 8'h00); model_cmd(8'h00);
    for (int k = 0; k < BUSY - 1; k++) begin
      @(negedge clk); chk("R11 restart", ready, 0);
    end
    @(negedge clk); chk("R11 restart rise", ready, 1);
    // R12 random mix
    for (int n = 0; n < 300; n++) begin
      data(16'($urandom));
      cmd(8'($urandom), "R12 random");
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule